// File: doc/BRIEF.md
# Card Data Block Receiver

This block takes one data block from a memory card on its data lines and hands it to a host one 32-bit word at a time. Once armed by a read-transfer command, it waits for the start bit on line 0, shifts in the programmed number of payload bytes, packs every four bytes into a word and holds that word in a receive data register. A host strobe reads the register and clears the ready flag.

After the payload, each active line carries its own 16-bit CRC followed by an end bit. The block checks these and raises a block-end flag, plus a CRC error flag if any check failed. A word that completes while the previous one is still unread raises a sticky overrun flag. The bus runs one bit wide or, when a configuration bit is set, four bits wide. Command issue and timeout counting belong to other blocks.

Top module: `card_blk_rx`

## Requirements
- R1: After reset, rx_ready_o, blk_end_o, crc_err_o, overrun_o, rdata_o and status_o are all zero.
- R2: The block length is taken from blk_len_i at the arm cycle with its two low bits forced to zero, so the word count is blk_len_i[15:2]. A count of zero goes from the start bit straight to the CRC bits. A 512-byte block yields 128 words.
- R3: Asserting arm_i for one cycle arms the receiver. The first later rising edge that samples dat_i[0] low is the start bit. The edge after it samples the first payload bit.
- R4: In 1-bit mode, bits arrive on dat_i[0] MSB first. The first byte lands in rdata_o[31:24]. A word is presented at the edge that samples its 32nd bit, and rdata_o changes at no other time.
- R5: With wide_i high at arm, each edge takes a nibble from dat_i[3:0], with dat_i[3] as its most significant bit and the high nibble of each byte first. A word then takes 8 edges.
- R6: rx_ready_o goes high when a word is presented and goes low after an edge where rd_i is high. If rd_i coincides with a word completing, rx_ready_o stays high.
- R7: overrun_o goes high when a word completes while rx_ready_o is high and rd_i is low. The new word replaces the old one, and overrun_o stays high until the next arm.
- R8: After the payload, every active line sends 16 CRC bits MSB first. The CRC is x^16+x^12+x^5+1 with a zero initial value, computed over that line's own payload bits. One end bit follows.
- R9: blk_end_o goes high at the edge that samples the end bit, which comes only after every word of the block. It stays high until the next arm.
- R10: crc_err_o goes high together with blk_end_o when any active line has a CRC mismatch or a low end bit. In 1-bit mode, dat_i[3:1] have no effect on it.
- R11: status_o carries rx_ready in bit 1, block end in bit 3, CRC error in bit 21 and overrun in bit 30. All other bits are zero.
- R12: arm_i clears all four flags and abandons any block in progress. rdata_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; data lines sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm for a new block, clears flags |
| wide_i | input | 1 | 0: 1-bit bus, 1: 4-bit bus (latched at arm) |
| blk_len_i | input | 16 | Block length in bytes (latched at arm) |
| dat_i | input | 4 | Card data lines |
| rd_i | input | 1 | Receive data register read strobe |
| rdata_o | output | 32 | Receive data register |
| rx_ready_o | output | 1 | Unread word present |
| blk_end_o | output | 1 | Block complete |
| crc_err_o | output | 1 | Data CRC or end-bit error |
| overrun_o | output | 1 | Unread word was overwritten |
| status_o | output | 32 | Status word with the flags at fixed bit positions |

## Verification
A wrong beat or word counter shows at the ports within one word time. rx_ready_o then rises on the wrong edge, or rdata_o holds a shifted pattern. A wrong CRC register or lane mask stays hidden until the end-bit edge, where crc_err_o differs from the value the bench computes. A stray flag update shows on the very next edge, because the bench model compares every flag, the data register and the status word after every clock. The blocks cover both widths, reads that are late, absent or coincident, aborted blocks, zero and odd lengths, and corrupted CRC and end bits.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_e;

  localparam int unsigned STAT_RDY_BIT = 1;
  localparam int unsigned STAT_END_BIT = 3;
  localparam int unsigned STAT_CRC_BIT = 21;
  localparam int unsigned STAT_OVR_BIT = 30;
endpackage

// File: rtl/card_rx_crc_lane.sv
module card_rx_crc_lane #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic rem_zero_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = bit_i ^ crc_q[CRC_W-1];

  // running division over payload and received CRC: zero remainder means match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  assign rem_zero_o = (crc_q == '0);
endmodule

// File: rtl/card_rx_packer.sv
module card_rx_packer #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              wide_i,
  input  logic [LANES-1:0]  dat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int unsigned CNT_W       = $clog2(WORD_W);
  localparam int unsigned BEATS_WIDE  = WORD_W / LANES;

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;

  assign limit  = wide_i ? CNT_W'(BEATS_WIDE - 1) : CNT_W'(WORD_W - 1);
  assign word_o = wide_i ? {sh_q[WORD_W-LANES-1:0], dat_i} : {sh_q[WORD_W-2:0], dat_i[0]};
  assign last_o = en_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= word_o;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/card_blk_rx.sv
module card_blk_rx
  import card_rx_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LANES    = 4,
  parameter int unsigned CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              wide_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic [LANES-1:0]  dat_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rx_ready_o,
  output logic              blk_end_o,
  output logic              crc_err_o,
  output logic              overrun_o,
  output logic [31:0]       status_o
);
  localparam int unsigned WCNT_W = LEN_W - 2;
  localparam int unsigned CCNT_W = $clog2(CRC_W);

  rx_state_e         state_q, state_d;
  logic              wide_q;
  logic [WCNT_W-1:0] words_q, wcnt_q;
  logic [CCNT_W-1:0] ccnt_q;
  logic [WORD_W-1:0] rdata_q, word_nxt;
  logic              word_last, last_word;
  logic              rdy_q, end_q, err_q, ovr_q;
  logic [LANES-1:0]  lane_act, rem_zero;
  logic              in_wait, in_data, in_crc, in_end;

  assign in_wait   = (state_q == ST_WAIT);
  assign in_data   = (state_q == ST_DATA);
  assign in_crc    = (state_q == ST_CRC);
  assign in_end    = (state_q == ST_END);
  assign last_word = word_last && (wcnt_q == words_q - 1'b1);

  card_rx_packer #(.WORD_W(WORD_W), .LANES(LANES)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_data),
    .en_i   (in_data),
    .wide_i (wide_q),
    .dat_i  (dat_i),
    .word_o (word_nxt),
    .last_o (word_last)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_main
      assign lane_act[l] = 1'b1;
    end else begin : g_aux
      assign lane_act[l] = wide_q;
    end
    card_rx_crc_lane #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (arm_i || in_wait),
      .en_i       (in_data || in_crc),
      .bit_i      (dat_i[l]),
      .rem_zero_o (rem_zero[l])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (!dat_i[0]) state_d = (words_q == '0) ? ST_CRC : ST_DATA;
      ST_DATA: if (last_word) state_d = ST_CRC;
      ST_CRC:  if (ccnt_q == CCNT_W'(CRC_W - 1)) state_d = ST_END;
      ST_END:  state_d = ST_IDLE;
      default: ;
    endcase
    if (arm_i) state_d = ST_WAIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wide_q  <= 1'b0;
      words_q <= '0;
      wcnt_q  <= '0;
      ccnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (arm_i) begin
        wide_q  <= wide_i;
        words_q <= blk_len_i[LEN_W-1:2];
        wcnt_q  <= '0;
        ccnt_q  <= '0;
      end else begin
        if (in_data && word_last) wcnt_q <= wcnt_q + 1'b1;
        if (in_crc)               ccnt_q <= ccnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rdy_q   <= 1'b0;
      end_q   <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (arm_i) begin
      rdy_q <= 1'b0;
      end_q <= 1'b0;
      err_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (in_data && word_last) begin
        rdata_q <= word_nxt;
        rdy_q   <= 1'b1;
        if (rdy_q && !rd_i) ovr_q <= 1'b1;
      end else if (rd_i) begin
        rdy_q <= 1'b0;
      end
      if (in_end) begin
        end_q <= 1'b1;
        err_q <= (|(lane_act & ~dat_i)) || (|(lane_act & ~rem_zero));
      end
    end
  end

  always_comb begin
    status_o               = '0;
    status_o[STAT_RDY_BIT] = rdy_q;
    status_o[STAT_END_BIT] = end_q;
    status_o[STAT_CRC_BIT] = err_q;
    status_o[STAT_OVR_BIT] = ovr_q;
  end

  assign rdata_o    = rdata_q;
  assign rx_ready_o = rdy_q;
  assign blk_end_o  = end_q;
  assign crc_err_o  = err_q;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/card_blk_rx_chk.sv
module card_blk_rx_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              rd_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rx_ready_o,
  input logic              blk_end_o,
  input logic              crc_err_o,
  input logic              overrun_o
);
  p_rdy_clear_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_ready_o) |-> ($past(rd_i) || $past(arm_i)));

  p_ovr_while_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ($past(rx_ready_o) && rx_ready_o));

  p_end_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_o && !arm_i) |=> blk_end_o);

  p_err_with_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> $rose(blk_end_o));

  p_arm_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !(rx_ready_o || blk_end_o || crc_err_o || overrun_o));

  p_data_moves_on_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> rx_ready_o);
endmodule

bind card_blk_rx card_blk_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .rx_ready_o (rx_ready_o),
  .blk_end_o  (blk_end_o),
  .crc_err_o  (crc_err_o),
  .overrun_o  (overrun_o)
);

// File: tb/card_blk_rx_bench.sv
module card_blk_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        arm_i, wide_i, rd_i;
  logic [15:0] blk_len_i;
  logic [3:0]  dat_i;
  logic [31:0] rdata_o, status_o;
  logic        rx_ready_o, blk_end_o, crc_err_o, overrun_o;

  always #5 clk_i = ~clk_i;

  card_blk_rx u_card_blk_rx (
    .clk_i, .rst_ni, .arm_i, .wide_i, .blk_len_i, .dat_i, .rd_i,
    .rdata_o, .rx_ready_o, .blk_end_o, .crc_err_o, .overrun_o, .status_o
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic  m_rdy = 0, m_end = 0, m_err = 0, m_ovr = 0;
  logic [31:0] m_data = '0;
  int    rd_lag = -1, rd_cnt = -1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", req, cur_req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] st;
    st = '0;
    st[1] = m_rdy; st[3] = m_end; st[21] = m_err; st[30] = m_ovr;
    chk("R4 rdata", rdata_o, m_data);
    chk("R6 rx_ready", {31'd0, rx_ready_o}, {31'd0, m_rdy});
    chk("R7 overrun", {31'd0, overrun_o}, {31'd0, m_ovr});
    chk("R9 blk_end", {31'd0, blk_end_o}, {31'd0, m_end});
    chk("R10 crc_err", {31'd0, crc_err_o}, {31'd0, m_err});
    chk("R11 status", status_o, st);
  endtask

  // one clock: drive, let the edge pass, advance model, compare
  task automatic do_cycle(logic arm, logic [3:0] d, logic ew, logic [31:0] w, logic ee, logic eerr);
    logic rd;
    @(negedge clk_i);
    rd = m_rdy && (rd_cnt == 0);
    arm_i = arm; dat_i = d; rd_i = rd;
    @(posedge clk_i);
    if (arm) begin
      m_rdy = 0; m_ovr = 0; m_end = 0; m_err = 0; rd_cnt = -1;
    end else begin
      if (ew) begin
        if (m_rdy && !rd) m_ovr = 1;
        m_rdy  = 1;
        m_data = w;
        rd_cnt = (rd_lag > 0) ? rd_lag - 1 : -1;
      end else if (rd) begin
        m_rdy = 0; rd_cnt = -1;
      end else if (rd_cnt > 0) begin
        rd_cnt--;
      end
      if (ee) begin m_end = 1; m_err = eerr; end
    end
    #2 compare_all();
  endtask

  function automatic logic [15:0] crc_next(logic [15:0] c, logic b);
    return (b ^ c[15]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
  endfunction

  task automatic send_block(int blen, bit wide, int lag, int idle, int bad_lane,
                            bit bad_end, int abort_at, bit junk);
    logic [31:0] wq[$];
    logic [15:0] crc[4];
    logic [3:0]  d;
    logic [2:0]  jb;
    int n, cyc, cpw;
    blk_len_i = blen[15:0];
    wide_i    = wide;
    rd_lag    = lag;
    do_cycle(1'b1, 4'hF, 0, '0, 0, 0);
    n   = blen / 4;
    cpw = wide ? 8 : 32;
    for (int i = 0; i < n; i++) wq.push_back($urandom);
    for (int l = 0; l < 4; l++) crc[l] = '0;
    cyc = 0;
    for (int i = 0; i < idle; i++) begin
      jb = junk ? 3'($urandom) : 3'b111;
      d  = wide ? 4'hF : {jb, 1'b1};
      if (abort_at >= 0 && cyc >= abort_at) return;
      do_cycle(1'b0, d, 0, '0, 0, 0); cyc++;
    end
    jb = junk ? 3'($urandom) : 3'b111;
    if (abort_at >= 0 && cyc >= abort_at) return;
    do_cycle(1'b0, wide ? 4'h0 : {jb, 1'b0}, 0, '0, 0, 0); cyc++;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < cpw; k++) begin
        jb = junk ? 3'($urandom) : 3'b111;
        if (wide) begin
          d = wq[i][31-4*k -: 4];
          for (int l = 0; l < 4; l++) crc[l] = crc_next(crc[l], d[l]);
        end else begin
          d = {jb, wq[i][31-k]};
          crc[0] = crc_next(crc[0], d[0]);
        end
        if (abort_at >= 0 && cyc >= abort_at) return;
        do_cycle(1'b0, d, k == cpw - 1, wq[i], 0, 0); cyc++;
      end
    end
    for (int j = 0; j < 16; j++) begin
      jb = junk ? 3'($urandom) : 3'b111;
      for (int l = 0; l < 4; l++) begin
        d[l] = crc[l][15-j];
        if (l == bad_lane && j == 5) d[l] = ~d[l];
      end
      if (!wide) d[3:1] = jb;
      if (abort_at >= 0 && cyc >= abort_at) return;
      do_cycle(1'b0, d, 0, '0, 0, 0); cyc++;
    end
    jb = junk ? 3'($urandom) : 3'b111;
    if (wide) d = bad_end ? 4'b1011 : 4'hF;
    else      d = {jb, !bad_end};
    do_cycle(1'b0, d, 0, '0, 1, bad_end || (bad_lane >= 0));
    for (int i = 0; i < 3; i++) do_cycle(1'b0, 4'hF, 0, '0, 0, 0);
  endtask

  initial begin
    rst_ni = 0; arm_i = 0; wide_i = 0; rd_i = 0; blk_len_i = '0; dat_i = 4'hF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    cur_req = "R1";
    compare_all();
    cur_req = "R4 R8 1-bit clean block";
    send_block(16, 0, 3, 2, -1, 0, -1, 0);
    cur_req = "R2 R5 4-bit, length 18 truncated to 16";
    send_block(18, 1, 2, 5, -1, 0, -1, 0);
    cur_req = "R3 long idle before start";
    send_block(8, 0, 1, 20, -1, 0, -1, 0);
    cur_req = "R7 unread words overrun";
    send_block(12, 0, -1, 1, -1, 0, -1, 0);
    cur_req = "R6 read coincides with next word";
    send_block(16, 0, 32, 1, -1, 0, -1, 0);
    cur_req = "R6 4-bit read coincides with next word";
    send_block(16, 1, 8, 1, -1, 0, -1, 0);
    cur_req = "R10 4-bit CRC corrupt lane 2";
    send_block(8, 1, 2, 1, 2, 0, -1, 0);
    cur_req = "R10 1-bit CRC corrupt lane 0";
    send_block(8, 0, 2, 1, 0, 0, -1, 0);
    cur_req = "R10 1-bit low end bit";
    send_block(8, 0, 2, 1, -1, 1, -1, 0);
    cur_req = "R10 4-bit low end bit";
    send_block(4, 1, 2, 1, -1, 1, -1, 0);
    cur_req = "R10 1-bit junk on upper lines";
    send_block(12, 0, 4, 3, -1, 0, -1, 1);
    cur_req = "R12 abort mid block";
    send_block(16, 0, 3, 2, -1, 0, 40, 0);
    cur_req = "R12 block after abort";
    send_block(8, 0, 3, 2, -1, 0, -1, 0);
    cur_req = "R2 zero length block";
    send_block(3, 0, 2, 2, -1, 0, -1, 0);
    cur_req = "R2 default 512-byte block";
    send_block(512, 1, 4, 2, -1, 0, -1, 0);
    cur_req = "R9 idle after end";
    for (int i = 0; i < 4; i++) do_cycle(1'b0, 4'h0, 0, '0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (%s): actual hung expected finished", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule